// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside the storage of a dual-clock FIFO and turns the core's write and read pointer counts into two early-warning flags. One flag, almost-empty, warns the consumer that few words remain. The other, almost-full, warns the producer that little room remains. Each flag compares the fill level against an offset register of its own. The two offsets are independent. A master reset loads one of eight built-in offset pairs, picked by three pins. Software can later replace the pair, either by shifting it in one bit at a time or by writing it from the write data bus. The pair can be read back on the read side whichever load method is in force.

Both the load method and the flag timing are latched during master reset. In asynchronous timing, each flag is raised by the clock of the side that pushes the level toward the boundary. It is lowered by the clock of the opposite side, and the comparison uses the raw pointers. In synchronous timing, each flag belongs wholly to one clock. Almost-empty lives on the read clock and almost-full on the write clock, and the pointer from the other clock arrives through a Gray-coded two-stage synchronizer. A partial reset restarts the flag and alternation state but keeps the offsets and both latched modes.

Top module: `pflag_unit`

## Requirements
- R1: Once settled, almost_empty is 1 exactly when the level (wr_ptr - rd_ptr modulo 2^(AW+1)) is less than or equal to the almost-empty offset.
- R2: Once settled, almost_full is 1 exactly when the level is greater than or equal to 2^AW minus the almost-full offset, so an offset of 0 flags only a completely full FIFO.
- R3: While mrst is high, the index {ld, def_sel[1], def_sel[0]} (ld is the MSB) loads the almost-empty offset with index+1 and the almost-full offset with 8-index.
- R4: In serial method (cfg_serial latched 1), every rising wclk edge with sen and ld high shifts sdi into a chain whose LSB end is the almost-empty register. After 2*AW shifts, the first bit sent is the almost-empty LSB and bit AW sent is the almost-full LSB. In parallel method these shifts are ignored.
- R5: In parallel method, every rising wclk edge with wen and ld high loads wdata into one offset. Writes alternate, starting with almost-empty after either reset. In serial method such writes are ignored.
- R6: Every rising rclk edge with ren and ld high places an offset on rb_data. Reads alternate, starting with almost-empty after either reset. rb_data is 0 after master reset and holds its value on every other rclk edge.
- R7: In asynchronous timing, almost_empty is raised only by an rclk edge and lowered only by a wclk edge. almost_full is raised only by a wclk edge and lowered only by an rclk edge.
- R8: In synchronous timing, almost_empty changes only on rclk and sees a wr_ptr change after one wclk edge and then three rclk edges. almost_full changes only on wclk and sees an rd_ptr change after one rclk edge and then three wclk edges.
- R9: cfg_serial and cfg_sync are sampled only while mrst is high. Changing them afterwards has no effect.
- R10: A partial reset keeps both offsets, the load method and the flag timing, and restarts both alternations at almost-empty.
- R11: After master or partial reset, with both pointers at zero, almost_empty is 1 and almost_full is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, held across edges of both clocks |
| prst | input | 1 | Partial reset, synchronous, held across edges of both clocks |
| def_sel | input | 2 | Low two bits of the default offset index during master reset |
| ld | input | 1 | Offset access strobe; MSB of the default index during master reset |
| cfg_serial | input | 1 | Load method, sampled during master reset: 1 serial, 0 parallel |
| cfg_sync | input | 1 | Flag timing, sampled during master reset: 1 synchronous, 0 asynchronous |
| wen | input | 1 | Write enable, used with ld for parallel loads |
| sen | input | 1 | Serial enable, used with ld for serial shifts |
| sdi | input | 1 | Serial offset data |
| wdata | input | AW | Write data bus used for parallel loads |
| wr_ptr | input | AW+1 | Write pointer count from the FIFO core (wclk domain) |
| ren | input | 1 | Read enable, used with ld for offset read-back |
| rd_ptr | input | AW+1 | Read pointer count from the FIFO core (rclk domain) |
| rb_data | output | AW | Offset read-back data |
| almost_empty | output | 1 | Almost-empty flag, active high |
| almost_full | output | 1 | Almost-full flag, active high |

## Verification
The bench drives each clock one pulse at a time, so the number of edges between a stimulus and its check is exact. Offset loads are checked through read-back, one rclk edge after the read strobe. Asynchronous flags are checked after an edge of the wrong clock, where they must not move, and then after the correct one. Synchronous flags are checked both one edge before and on the edge where the synchronized pointer takes effect (one source edge plus three destination edges). For the level sweeps, four alternating edges of each clock are allowed before the arithmetic flag values are compared.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    // Which offset register a parallel write or a read-back touches next.
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } off_sel_e;

    // Built-in almost-empty offset for default index 0..7.
    function automatic logic [7:0] dflt_ae(input logic [2:0] idx);
        return 8'(idx) + 8'd1;
    endfunction

    // Built-in almost-full offset for default index 0..7.
    function automatic logic [7:0] dflt_af(input logic [2:0] idx);
        return 8'd8 - 8'(idx);
    endfunction

endpackage

// File: rtl/pflag_offsets.sv
// Write-clock side: latched modes and the two offset registers.
module pflag_offsets
    import pflag_pkg::*;
#(
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic [2:0]    def_idx,
    input  logic          cfg_serial,
    input  logic          cfg_sync,
    input  logic          wen,
    input  logic          sen,
    input  logic          ld,
    input  logic          sdi,
    input  logic [OW-1:0] wdata,
    output logic [OW-1:0] ae_off,
    output logic [OW-1:0] af_off,
    output logic          sync_mode
);

    typedef struct packed {
        logic [OW-1:0] ae;
        logic [OW-1:0] af;
        logic          ser;
        logic          sync;
        off_sel_e      wsel;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mrst) begin
            st_d.ae   = OW'(dflt_ae(def_idx));
            st_d.af   = OW'(dflt_af(def_idx));
            st_d.ser  = cfg_serial;
            st_d.sync = cfg_sync;
            st_d.wsel = SEL_AE;
        end else if (prst) begin
            st_d.wsel = SEL_AE;
        end else if (st_q.ser) begin
            if (sen && ld) begin
                {st_d.af, st_d.ae} = {sdi, st_q.af, st_q.ae[OW-1:1]};
            end
        end else if (wen && ld) begin
            if (st_q.wsel == SEL_AE) begin
                st_d.ae   = wdata;
                st_d.wsel = SEL_AF;
            end else begin
                st_d.af   = wdata;
                st_d.wsel = SEL_AE;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ae_off    = st_q.ae;
    assign af_off    = st_q.af;
    assign sync_mode = st_q.sync;

    // R5 R9 R10
    ser_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        (st_q.ser && !(sen && ld)) |=> $stable({ae_off, af_off}));

    // R4 R9 R10
    par_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        (!st_q.ser && !(wen && ld)) |=> $stable({ae_off, af_off}));

    // R5
    par_first_chk: assert property (@(posedge clk) disable iff (mrst)
        (!st_q.ser && !prst && wen && ld && st_q.wsel == SEL_AE)
            |=> (ae_off == $past(wdata)) && $stable(af_off));

endmodule

// File: rtl/pflag_readback.sv
// Read-clock side: offset read-back and the read-domain copy of the timing mode.
module pflag_readback
    import pflag_pkg::*;
#(
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          cfg_sync,
    input  logic          ren,
    input  logic          ld,
    input  logic [OW-1:0] ae_off,
    input  logic [OW-1:0] af_off,
    output logic [OW-1:0] rb_data,
    output logic          sync_mode
);

    typedef struct packed {
        logic [OW-1:0] rb;
        off_sel_e      rsel;
        logic          sync;
    } rst_t;

    rst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mrst) begin
            st_d.rb   = '0;
            st_d.rsel = SEL_AE;
            st_d.sync = cfg_sync;
        end else if (prst) begin
            st_d.rsel = SEL_AE;
        end else if (ren && ld) begin
            if (st_q.rsel == SEL_AE) begin
                st_d.rb   = ae_off;
                st_d.rsel = SEL_AF;
            end else begin
                st_d.rb   = af_off;
                st_d.rsel = SEL_AE;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rb_data   = st_q.rb;
    assign sync_mode = st_q.sync;

    // R6
    rb_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        !(ren && ld) |=> $stable(rb_data));

    // R10
    rb_restart_chk: assert property (@(posedge clk) disable iff (mrst)
        prst ##1 (ren && ld && !prst) |=> rb_data == $past(ae_off));

endmodule

// File: rtl/pflag_gsync.sv
// Pointer crossing: Gray register in the source domain, two flops in the destination.
module pflag_gsync #(
    parameter int W = 5
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] bin_i,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] bin_o
);

    logic [W-1:0] gray_d, gray_q;
    logic [W-1:0] s1_d, s1_q;
    logic [W-1:0] s2_d, s2_q;

    always_comb begin
        gray_d = src_rst ? '0 : (bin_i ^ (bin_i >> 1));
    end

    always_ff @(posedge src_clk) begin
        gray_q <= gray_d;
    end

    always_comb begin
        s1_d = dst_rst ? '0 : gray_q;
        s2_d = dst_rst ? '0 : s1_q;
    end

    always_ff @(posedge dst_clk) begin
        s1_q <= s1_d;
        s2_q <= s2_d;
    end

    // Gray back to binary: each bit is the XOR of itself and all higher bits.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_o[i] = ^(s2_q >> i);
        end
    end

endmodule

// File: rtl/pflag_flag.sv
// One programmable flag. The set clock raises it, the clear clock lowers it
// (asynchronous timing); in synchronous timing the set clock owns it alone.
module pflag_flag #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic set_clk,
    input  logic set_rst,
    input  logic clr_clk,
    input  logic clr_rst,
    input  logic sync_mode,
    input  logic cond_async,
    input  logic cond_sync,
    output logic flag
);

    typedef struct packed {
        logic tgl;
        logic hold;
    } sst_t;

    sst_t s_d, s_q;
    logic c_d, c_q;
    logic flag_async;

    assign flag_async = s_q.tgl ^ c_q;

    always_comb begin
        s_d = s_q;
        if (set_rst) begin
            s_d.tgl  = RST_VAL;
            s_d.hold = RST_VAL;
        end else begin
            s_d.hold = cond_sync;
            if (!flag_async && cond_async) begin
                s_d.tgl = ~s_q.tgl;
            end
        end
    end

    always_comb begin
        c_d = c_q;
        if (clr_rst) begin
            c_d = 1'b0;
        end else if (flag_async && !cond_async) begin
            c_d = ~c_q;
        end
    end

    always_ff @(posedge set_clk) begin
        s_q <= s_d;
    end

    always_ff @(posedge clr_clk) begin
        c_q <= c_d;
    end

    assign flag = sync_mode ? s_q.hold : flag_async;

endmodule

// File: rtl/pflag_unit.sv
module pflag_unit #(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst,
    input  logic          prst,
    input  logic [1:0]    def_sel,
    input  logic          ld,
    input  logic          cfg_serial,
    input  logic          cfg_sync,
    input  logic          wen,
    input  logic          sen,
    input  logic          sdi,
    input  logic [AW-1:0] wdata,
    input  logic [AW:0]   wr_ptr,
    input  logic          ren,
    input  logic [AW:0]   rd_ptr,
    output logic [AW-1:0] rb_data,
    output logic          almost_empty,
    output logic          almost_full
);

    localparam int PW    = AW + 1;
    localparam int OW    = AW;
    localparam int DEPTH = 1 << AW;

    logic [OW-1:0] ae_off, af_off;
    logic          sync_w, sync_r;
    logic          rst_any;
    logic [PW-1:0] wr_sync, rd_sync;
    logic [PW-1:0] lvl_raw, lvl_rd, lvl_wr, af_thr;

    assign rst_any = mrst | prst;

    pflag_offsets #(.OW(OW)) u_offs (
        .clk       (wclk),
        .mrst      (mrst),
        .prst      (prst),
        .def_idx   ({ld, def_sel}),
        .cfg_serial(cfg_serial),
        .cfg_sync  (cfg_sync),
        .wen       (wen),
        .sen       (sen),
        .ld        (ld),
        .sdi       (sdi),
        .wdata     (wdata),
        .ae_off    (ae_off),
        .af_off    (af_off),
        .sync_mode (sync_w)
    );

    pflag_readback #(.OW(OW)) u_rback (
        .clk      (rclk),
        .mrst     (mrst),
        .prst     (prst),
        .cfg_sync (cfg_sync),
        .ren      (ren),
        .ld       (ld),
        .ae_off   (ae_off),
        .af_off   (af_off),
        .rb_data  (rb_data),
        .sync_mode(sync_r)
    );

    pflag_gsync #(.W(PW)) u_wsync (
        .src_clk(wclk),
        .src_rst(rst_any),
        .bin_i  (wr_ptr),
        .dst_clk(rclk),
        .dst_rst(rst_any),
        .bin_o  (wr_sync)
    );

    pflag_gsync #(.W(PW)) u_rsync (
        .src_clk(rclk),
        .src_rst(rst_any),
        .bin_i  (rd_ptr),
        .dst_clk(wclk),
        .dst_rst(rst_any),
        .bin_o  (rd_sync)
    );

    assign lvl_raw = wr_ptr - rd_ptr;
    assign lvl_rd  = wr_sync - rd_ptr;
    assign lvl_wr  = wr_ptr - rd_sync;
    assign af_thr  = PW'(DEPTH) - PW'(af_off);

    pflag_flag #(.RST_VAL(1'b1)) u_ae (
        .set_clk   (rclk),
        .set_rst   (rst_any),
        .clr_clk   (wclk),
        .clr_rst   (rst_any),
        .sync_mode (sync_r),
        .cond_async(lvl_raw <= PW'(ae_off)),
        .cond_sync (lvl_rd <= PW'(ae_off)),
        .flag      (almost_empty)
    );

    pflag_flag #(.RST_VAL(1'b0)) u_af (
        .set_clk   (wclk),
        .set_rst   (rst_any),
        .clr_clk   (rclk),
        .clr_rst   (rst_any),
        .sync_mode (sync_w),
        .cond_async(lvl_raw >= af_thr),
        .cond_sync (lvl_wr >= af_thr),
        .flag      (almost_full)
    );

endmodule

// File: tb/tb_pflag_unit.sv
module tb_pflag_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int PW = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 0, rclk = 0, mrst = 1, prst = 0;
    logic [1:0]    def_sel = 0;
    logic          ld = 0, cfg_serial = 0, cfg_sync = 0;
    logic          wen = 0, sen = 0, sdi = 0, ren = 0;
    logic [AW-1:0] wdata = 0;
    logic [PW-1:0] wr_ptr = 0, rd_ptr = 0;
    logic [AW-1:0] rb_data;
    logic          almost_empty, almost_full;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    pflag_unit #(.AW(AW)) dut (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
        .def_sel(def_sel), .ld(ld), .cfg_serial(cfg_serial), .cfg_sync(cfg_sync),
        .wen(wen), .sen(sen), .sdi(sdi), .wdata(wdata), .wr_ptr(wr_ptr),
        .ren(ren), .rd_ptr(rd_ptr), .rb_data(rb_data),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_w();
        #(CLK_PERIOD / 2) wclk = 1;
        #(CLK_PERIOD / 2) wclk = 0;
    endtask

    task automatic tick_r();
        #(CLK_PERIOD / 2) rclk = 1;
        #(CLK_PERIOD / 2) rclk = 0;
    endtask

    task automatic tick_both(input int n);
        for (int i = 0; i < n; i++) begin
            tick_w();
            tick_r();
        end
    endtask

    task automatic master_reset(input int idx, input logic ser, input logic syn);
        mrst = 1; def_sel = idx[1:0]; ld = idx[2];
        cfg_serial = ser; cfg_sync = syn;
        wr_ptr = 0; rd_ptr = 0;
        tick_both(3);
        mrst = 0; ld = 0; def_sel = 0;
        cfg_serial = ~ser; cfg_sync = ~syn;   // R9: later values must not matter
    endtask

    task automatic read_back(output logic [AW-1:0] v);
        ren = 1; ld = 1;
        tick_r();
        ren = 0; ld = 0;
        v = rb_data;
    endtask

    task automatic par_load(input int ae, input int af);
        wen = 1; ld = 1;
        wdata = AW'(ae); tick_w();
        wdata = AW'(af); tick_w();
        wen = 0; ld = 0;
    endtask

    task automatic ser_load(input int ae, input int af);
        sen = 1; ld = 1;
        for (int i = 0; i < 2 * AW; i++) begin
            sdi = (i < AW) ? ae[i] : af[i - AW];
            tick_w();
        end
        sen = 0; ld = 0; sdi = 0;
    endtask

    task automatic sweep(input string tag, input int ae, input int af);
        for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            rd_ptr = PW'(27);
            wr_ptr = PW'(27 + lvl);
            tick_both(4);
            chk({"R1 ", tag}, almost_empty, (lvl <= ae) ? 1 : 0);
            chk({"R2 ", tag}, almost_full, (lvl >= DEPTH - af) ? 1 : 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] v;

        // R3 / R11 / R6 reset state: every default index
        for (int idx = 0; idx < 8; idx++) begin
            master_reset(idx, 1'b0, idx[0]);
            chk("R11 ae after mrst", almost_empty, 1);
            chk("R11 af after mrst", almost_full, 0);
            chk("R6 rb after mrst", rb_data, 0);
            read_back(v); chk("R3 default ae", v, idx + 1);
            read_back(v); chk("R3 default af", v, 8 - idx);
        end

        // Parallel method, synchronous timing
        master_reset(0, 1'b0, 1'b1);
        par_load(5, 3);
        read_back(v); chk("R5 parallel ae", v, 5);
        read_back(v); chk("R5 parallel af", v, 3);
        ren = 1; ld = 0; tick_r(); ren = 0;
        chk("R6 hold without ld", rb_data, 3);
        ser_load(15, 15);
        read_back(v); chk("R4 serial ignored ae", v, 5);
        read_back(v); chk("R4 serial ignored af", v, 3);
        sweep("sync 5/3", 5, 3);
        par_load(0, 0);
        sweep("sync 0/0", 0, 0);
        par_load(5, 3);

        // R8 synchronous latency
        wr_ptr = 0; rd_ptr = 0; tick_both(4);
        chk("R8 ae start", almost_empty, 1);
        wr_ptr = 8;
        tick_w(); tick_r(); tick_r();
        chk("R8 ae one rclk early", almost_empty, 1);
        tick_r();
        chk("R8 ae on third rclk", almost_empty, 0);
        rd_ptr = 6;
        tick_w(); tick_w(); tick_w();
        chk("R8 ae ignores wclk", almost_empty, 0);
        tick_r();
        chk("R8 ae on rclk", almost_empty, 1);
        wr_ptr = 20;
        tick_w();
        chk("R8 af own wclk", almost_full, 1);
        tick_both(4);
        rd_ptr = 10;
        tick_r(); tick_w(); tick_w();
        chk("R8 af one wclk early", almost_full, 1);
        tick_w();
        chk("R8 af on third wclk", almost_full, 0);

        // Asynchronous timing
        master_reset(0, 1'b0, 1'b0);
        par_load(5, 3);
        sweep("async 5/3", 5, 3);
        par_load(0, 0);
        sweep("async 0/0", 0, 0);
        par_load(5, 3);
        wr_ptr = 8; rd_ptr = 0; tick_both(2);
        chk("R7 ae start", almost_empty, 0);
        chk("R7 af start", almost_full, 0);
        rd_ptr = 4;
        tick_w();
        chk("R7 ae not raised by wclk", almost_empty, 0);
        tick_r();
        chk("R7 ae raised by rclk", almost_empty, 1);
        wr_ptr = 12;
        tick_r();
        chk("R7 ae not lowered by rclk", almost_empty, 1);
        tick_w();
        chk("R7 ae lowered by wclk", almost_empty, 0);
        wr_ptr = 18;
        tick_r();
        chk("R7 af not raised by rclk", almost_full, 0);
        tick_w();
        chk("R7 af raised by wclk", almost_full, 1);
        rd_ptr = 8;
        tick_w();
        chk("R7 af not lowered by wclk", almost_full, 1);
        tick_r();
        chk("R7 af lowered by rclk", almost_full, 0);

        // Serial method, cfg pins changed after reset
        master_reset(0, 1'b1, 1'b0);
        ser_load(10, 6);
        read_back(v); chk("R4 serial ae", v, 10);
        read_back(v); chk("R4 serial af", v, 6);
        par_load(1, 1);
        read_back(v); chk("R5 R9 parallel ignored ae", v, 10);
        read_back(v); chk("R5 R9 parallel ignored af", v, 6);
        read_back(v); chk("R6 alternation ae", v, 10);

        // R10 partial reset
        wr_ptr = 9; rd_ptr = 1; tick_both(2);
        prst = 1; wr_ptr = 0; rd_ptr = 0;
        tick_both(2);
        prst = 0;
        chk("R10 R11 ae after prst", almost_empty, 1);
        chk("R10 R11 af after prst", almost_full, 0);
        read_back(v); chk("R10 restart at ae", v, 10);
        read_back(v); chk("R10 af kept", v, 6);
        par_load(2, 2);
        read_back(v); chk("R10 serial method kept", v, 10);
        read_back(v); chk("R10 serial method kept af", v, 6);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule